// File: doc/BRIEF.md
# Prescaled Multi-Channel Pulse Generator

This block produces up to four independent pulse-width-modulated outputs. Each channel has one 32-bit configuration word with three fields: a run flag, an 8-bit high-time value and a 13-bit clock divider. The divider turns the core clock into a slower tick. An 8-bit tick counter wraps every 256 ticks, so the length of a period depends only on the divider. The output of a channel is high while its tick counter is below the high-time value.

Software reaches the words over a small request/response bus. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A write has no response. A read returns its word on the response channel one cycle after it is taken. The block holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` is high. While a response waits and `rsp_ready` is low, `req_ready` is low, and this is the only back-pressure. New high-time and divider values reach a running channel at the next period boundary, so no period is ever cut short.

Top module: `pwm_ctrl`

## Requirements
- R1: After reset every output is low, `req_ready` is high, `rsp_valid` is low, and every configuration word reads as zero.
- R2: Word layout: bit 31 is the run flag, bits [23:16] are the high time, bits [12:0] are the divider. A read returns these fields as they were written, and all other bits read as zero.
- R3: Channel n sits at byte address n*16. A request whose low four address bits are not zero, or whose channel index is NUM_CH or above, writes nothing and reads zero.
- R4: While the run flag is clear, the channel output is low. Clearing the flag drives the output low in the first cycle after the write is taken, and the next run starts from the start of a period.
- R5: Take the write that sets a clear run flag as accepted at edge E, and count the cycles after E as k = 0, 1, 2 and so on. With divider S and high time D, the output in cycle k is high exactly when floor(k/(S+1)) mod 256 < D. This also holds for the largest divider, 8191.
- R6: A high time of 0 keeps the output low. A high time of 255 keeps the output high for all but S+1 cycles of each 256*(S+1)-cycle period.
- R7: A high time or divider written while the channel runs takes effect at the next period boundary. A write taken on the boundary edge itself waits one more full period.
- R8: A read taken at an edge gives `rsp_valid` in the next cycle. The response holds with stable data while `rsp_ready` is low, and during that time `req_ready` is low.
- R9: Writes and waveforms of one channel leave every other channel's word and output unchanged.
- R10: Writing all zeros to a word stops the channel and clears its high time and divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| pwm_out | output | NUM_CH | One pulse output per channel |

## Verification
The tightest collision is a configuration write that lands on the same edge where a running channel crosses its period boundary and reloads its active high time and divider. The bench uses its own timing model to find the cycle before a boundary and places a write there. It then counts high cycles over the next two periods, expecting the old high time first and the new one second. Random writes with small dividers make the same collision happen many more times, and the bench compares every channel output against its model on every cycle.

// File: rtl/pwm_ctrl_pkg.sv
package pwm_ctrl_pkg;
  localparam int DUTY_W     = 8;
  localparam int SCALE_W    = 13;
  localparam int WORD_W     = 32;
  localparam int RUN_BIT    = 31;
  localparam int DUTY_LSB   = 16;
  localparam int SCALE_LSB  = 0;
  localparam int SLOT_SHIFT = 4;
  localparam logic [WORD_W-1:0] CFG_MASK = 32'h80FF_1FFF;

  typedef struct packed {
    logic              run;
    logic [DUTY_W-1:0] duty;
    logic [SCALE_W-1:0] scale;
  } chan_cfg_t;

  function automatic logic [WORD_W-1:0] pack_cfg(input chan_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RUN_BIT] = c.run;
    w[DUTY_LSB +: DUTY_W] = c.duty;
    w[SCALE_LSB +: SCALE_W] = c.scale;
    return w;
  endfunction
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [WORD_W-1:0]       rsp_rdata,
  output chan_cfg_t [NUM_CH-1:0]  cfg_o
);
  localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

  logic               req_fire;
  logic               sub_zero;
  logic [SLOT_W-1:0]  slot;
  logic [NUM_CH-1:0]  sel;
  logic [WORD_W-1:0]  rd_word;
  logic               rsp_valid_q;
  logic [WORD_W-1:0]  rsp_data_q;
  chan_cfg_t          wr_cfg;
  logic               unused_wbits;

  assign unused_wbits = ^(req_wdata & ~CFG_MASK);

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign sub_zero  = (req_addr[SLOT_SHIFT-1:0] == '0);
  assign slot      = req_addr[ADDR_W-1:SLOT_SHIFT];

  assign wr_cfg.run   = req_wdata[RUN_BIT];
  assign wr_cfg.duty  = req_wdata[DUTY_LSB +: DUTY_W];
  assign wr_cfg.scale = req_wdata[SCALE_LSB +: SCALE_W];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    assign sel[i] = sub_zero && (slot == SLOT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[i] <= '0;
      end else if (req_fire && req_write && sel[i]) begin
        cfg_o[i] <= wr_cfg;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel[i]) rd_word = rd_word | pack_cfg(cfg_o[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (req_fire && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
endmodule

// File: rtl/pwm_ctrl_chan.sv
module pwm_ctrl_chan
  import pwm_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chan_cfg_t cfg,
  output logic      pwm_o
);
  logic               run_q;
  logic [DUTY_W-1:0]  act_duty_q;
  logic [SCALE_W-1:0] act_scale_q;
  logic [SCALE_W-1:0] pre_q;
  logic [DUTY_W-1:0]  tick_q;
  logic [DUTY_W-1:0]  eff_duty;
  logic [SCALE_W-1:0] eff_scale;
  logic               tick_hit;
  logic               wrap;

  // First running cycle uses the freshly written word directly.
  assign eff_duty  = run_q ? act_duty_q  : cfg.duty;
  assign eff_scale = run_q ? act_scale_q : cfg.scale;
  assign tick_hit  = (pre_q == eff_scale);
  assign wrap      = tick_hit && (tick_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      act_duty_q  <= '0;
      act_scale_q <= '0;
      pre_q       <= '0;
      tick_q      <= '0;
    end else if (!cfg.run) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      tick_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (!run_q || wrap) begin
        act_duty_q  <= cfg.duty;
        act_scale_q <= cfg.scale;
      end
      if (tick_hit) begin
        pre_q  <= '0;
        tick_q <= tick_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign pwm_o = cfg.run && (tick_q < eff_duty);
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  chan_cfg_t [NUM_CH-1:0] ch_cfg;
  logic      [NUM_CH-1:0] ch_run;

  pwm_ctrl_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .cfg_o     (ch_cfg)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    assign ch_run[i] = ch_cfg[i].run;
    pwm_ctrl_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg   (ch_cfg[i]),
      .pwm_o (pwm_out[i])
    );
  end
endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk
  import pwm_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] ch_run
);
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R8

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R8

  AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~CFG_MASK) == '0)); // R2

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[i] |-> !pwm_out[i]); // R4
  end
endmodule

bind pwm_ctrl pwm_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .pwm_out   (pwm_out),
  .ch_run    (ch_run)
);

// File: tb/pwm_ctrl_tb.sv
module pwm_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;
  localparam logic [31:0] MASK = 32'h80FF_1FFF;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NUM_CH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] sh [NUM_CH];
  int m_k [NUM_CH];
  int m_d [NUM_CH];
  int m_s [NUM_CH];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pwm_out(pwm_out)
  );

  function automatic bit addr_ok(input logic [ADDR_W-1:0] a);
    return (a[3:0] == 4'd0) && (int'(a[ADDR_W-1:4]) < NUM_CH);
  endfunction

  function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
    if (addr_ok(a)) return sh[int'(a[ADDR_W-1:4])];
    return 32'd0;
  endfunction

  function automatic bit exp_out(input int ch);
    if (!sh[ch][31]) return 1'b0;
    return (m_k[ch] / (m_s[ch] + 1)) < m_d[ch];
  endfunction

  // timing model built from R5/R7: k counts cycles since run start or boundary
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        sh[c] <= '0; m_k[c] <= 0; m_d[c] <= 0; m_s[c] <= 0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (sh[c][31]) begin
          if (m_k[c] == 256 * (m_s[c] + 1) - 1) begin
            m_k[c] <= 0;
            m_d[c] <= int'(sh[c][23:16]);
            m_s[c] <= int'(sh[c][12:0]);
          end else begin
            m_k[c] <= m_k[c] + 1;
          end
        end
      end
      if (req_valid && req_write && addr_ok(req_addr)) begin
        automatic int c = int'(req_addr[ADDR_W-1:4]);
        automatic logic [31:0] nw = req_wdata & MASK;
        sh[c] <= nw;
        if (!sh[c][31] && nw[31]) begin
          m_k[c] <= 0;
          m_d[c] <= int'(nw[23:16]);
          m_s[c] <= int'(nw[12:0]);
        end
      end
    end
  end

  // every-cycle waveform comparison (R5, R4, R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NUM_CH; c++) begin
        checks++;
        if (pwm_out[c] !== exp_out(c)) begin
          errors++;
          $display("FAIL R5 ch%0d cycle %0d out=%b exp=%b", c, cyc, pwm_out[c], exp_out(c));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d act=running exp=finished", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input string req, input logic [ADDR_W-1:0] a);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    e = exp_read(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({req, " rdata"}, rsp_rdata, e);
  endtask

  task automatic count_high(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      cnt += int'(pwm_out[ch]);
      @(negedge clk);
    end
  endtask

  initial begin
    int cnt;
    logic [31:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {28'd0, pwm_out}, 32'd0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < NUM_CH; c++) bus_rd("R1 word", ADDR_W'(c * 16));

    // R2 layout and reserved bits, R10 clear
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd("R2 readback", 8'h00);
    chk("R2 mask", sh[0], 32'h80FF_1FFF);
    bus_wr(8'h20, 32'h0012_0005);
    bus_rd("R2 fields", 8'h20);
    bus_wr(8'h00, 32'h0);
    bus_rd("R10 zeroed", 8'h00);
    chk("R10 out low", {31'd0, pwm_out[0]}, 32'd0);

    // R3 decode
    bus_wr(8'h14, 32'h8001_0000);
    bus_rd("R3 offset write ignored", 8'h10);
    bus_rd("R3 offset read zero", 8'h14);
    bus_wr(8'h40, 32'h8080_0000);
    bus_rd("R3 slot beyond count", 8'h40);
    bus_wr(8'h38, 32'h8080_0000);
    bus_rd("R3 misaligned", 8'h30);

    // R6 duty 0 and duty 255
    bus_wr(8'h00, 32'h8000_0000);
    count_high(0, 512, cnt);
    chk("R6 duty0 high count", cnt, 0);
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h00, 32'h80FF_0001);
    count_high(0, 512, cnt);
    chk("R6 duty255 high count", cnt, 510);
    bus_wr(8'h00, 32'h0);

    // R5 largest divider
    bus_wr(8'h10, 32'h8001_1FFF);
    count_high(1, 8292, cnt);
    chk("R5 max divider high count", cnt, 8192);
    bus_wr(8'h10, 32'h0);

    // R4 stop while high, then restart from period start
    bus_wr(8'h30, 32'h8080_0000);
    repeat (20) @(negedge clk);
    bus_wr(8'h30, 32'h0080_0000);
    chk("R4 low after stop", {31'd0, pwm_out[3]}, 32'd0);
    bus_wr(8'h30, 32'h8003_0000);
    count_high(3, 256, cnt);
    chk("R4 restart high count", cnt, 3);
    bus_wr(8'h30, 32'h0);

    // R7 write landing on the boundary edge
    bus_wr(8'h00, 32'h800A_0000);
    while (m_k[0] != 255) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_wdata = 32'h80C8_0000;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    count_high(0, 256, cnt);
    chk("R7 old duty kept", cnt, 10);
    count_high(0, 256, cnt);
    chk("R7 new duty applied", cnt, 200);
    bus_wr(8'h00, 32'h0);

    // R8 response stall
    bus_wr(8'h10, 32'h0033_0007);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10;
    @(negedge clk);
    req_valid = 1'b0;
    held = rsp_rdata;
    for (int i = 0; i < 3; i++) begin
      chk("R8 valid held", {31'd0, rsp_valid}, 32'd1);
      chk("R8 ready low", {31'd0, req_ready}, 32'd0);
      chk("R8 data stable", rsp_rdata, 32'h0033_0007);
      @(negedge clk);
    end
    chk("R8 data unchanged", rsp_rdata, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R8 released", {31'd0, rsp_valid}, 32'd0);

    // R9 random mix, all channels checked every cycle by the model
    for (int n = 0; n < 400; n++) begin
      automatic int c = $urandom % NUM_CH;
      automatic int op = $urandom % 8;
      automatic logic [31:0] w = $urandom;
      automatic logic [ADDR_W-1:0] a = ADDR_W'(c * 16);
      w[31] = ($urandom % 4) != 0;
      w[12:0] = 13'($urandom % 4);
      if (op == 0) a = ADDR_W'($urandom);
      if (op < 5) bus_wr(a, w);
      else bus_rd("R9 random read", a);
      repeat ($urandom % 300) @(negedge clk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule